// File: doc/BRIEF.md
# Prioritized Interrupt-Level Combiner

The block collects thirteen level-sensitive interrupt lines and turns them into one 4-bit encoded level for a processor's level-encoded interrupt input. Every line has a fixed priority level (0 is the most urgent) and its own bit in a 16-bit pending vector. Software enables lines through a 16-bit mask register. Among the lines that are both pending and enabled, the one with the lowest level wins. The winning level is inverted (XOR 15) before it leaves the block, so an idle block drives 0.

A small 16-bit register window sits on a simple synchronous bus: the mask register, a general-purpose output-port register, a power-off register that emits a one-cycle request pulse, and a fixed version register. Reads are combinational from the current address. The source lines are assumed to be synchronous to `clk`.

Top module: `irq_level_combiner`

## Requirements
- R1: Input `src[k]` is the line with priority level k (k = 0..12). Its pending/mask bit position is, for k = 0..12 in turn: 11, 9, 8, 12, 10, 6, 5, 4, 7, 14, 13, 0, 15. Pending bits 1, 2 and 3 are never set.
- R2: A line takes part in arbitration only when its pending bit and the mask bit at the same position are both 1. A mask of 0 gives output 0 whatever the lines do.
- R3: Among participating lines, the lowest level wins. With no participant the selected level is 15.
- R4: `irl_code` equals the selected level XOR 15. It is registered: it reflects line levels and mask contents as they stand after the same clock edge, including a mask write and a line change in the same cycle.
- R5: A write at byte offset 0x00 loads all 16 mask bits. A read there returns the mask.
- R6: A write at offset 0x36 loads the 16-bit output-port register. It drives `out_port` and reads back at 0x36.
- R7: A write at offset 0x30 with data bit 0 set makes `poweroff_req` high for exactly the next cycle. With bit 0 clear, no pulse follows. A read at 0x30 returns 0.
- R8: A read at offset 0x32 always returns 0x0010. Writes there change nothing.
- R9: Every other offset, odd ones included, reads 0. Writes there change neither the mask nor the output port.
- R10: Synchronous reset (`rst` high at an edge) clears the mask, the pending vector and the output port. It forces `irl_code` to 0 and `poweroff_req` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src | input | 13 | Interrupt lines, bit k has priority level k |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 6 | Byte offset inside the 0x40-byte window |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| out_port | output | 16 | General-purpose output-port register |
| irl_code | output | 4 | Inverted encoded winning level |
| poweroff_req | output | 1 | One-cycle power-off request |

## Verification
A mask write and a change on the interrupt lines can land on the same clock edge. The encoded level must then follow the new mask applied to the new line levels, with no stale mix of the two. The bench provokes this with directed steps: one write enables a bit while the matching line rises, and another disables the current winner while a lower-priority line rises. A pseudo-random phase then mixes writes and line changes on every cycle. The reference model applies both updates at the edge and only then computes the expected code, which is compared one cycle later.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int IRQC_LVL_W   = 4;
  localparam int IRQC_VEC_W   = 16;
  localparam int IRQC_MAX_SRC = 15;

  // Position in the pending/mask vector owned by the line of a given level.
  function automatic logic [3:0] irqc_bit_of(input int lvl);
    case (lvl)
      0:       return 4'd11;
      1:       return 4'd9;
      2:       return 4'd8;
      3:       return 4'd12;
      4:       return 4'd10;
      5:       return 4'd6;
      6:       return 4'd5;
      7:       return 4'd4;
      8:       return 4'd7;
      9:       return 4'd14;
      10:      return 4'd13;
      11:      return 4'd0;
      12:      return 4'd15;
      default: return 4'd1;
    endcase
  endfunction

  // Lowest participating level, 15 when the vector is empty.
  function automatic logic [IRQC_LVL_W-1:0] irqc_select(input logic [IRQC_VEC_W-1:0] vec,
                                                        input int nsrc);
    logic [IRQC_LVL_W-1:0] best;
    best = 4'hF;
    for (int l = IRQC_MAX_SRC - 1; l >= 0; l--) begin
      if (l < nsrc && vec[irqc_bit_of(l)]) best = 4'(l);
    end
    return best;
  endfunction

  function automatic logic [IRQC_LVL_W-1:0] irqc_invert(input logic [IRQC_LVL_W-1:0] lvl);
    return lvl ^ 4'hF;
  endfunction
endpackage

// File: rtl/irqc_pending.sv
module irqc_pending
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 13,
  parameter int VEC_W   = IRQC_VEC_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src,
  output logic [VEC_W-1:0]   pend_d,
  output logic [VEC_W-1:0]   pend_q
);
  always_comb begin
    pend_d = '0;
    for (int k = 0; k < NUM_SRC; k++) pend_d[irqc_bit_of(k)] = src[k];
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_d;
  end
endmodule

// File: rtl/irqc_encoder.sv
module irqc_encoder
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 13,
  parameter int VEC_W   = IRQC_VEC_W,
  parameter int LVL_W   = IRQC_LVL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [VEC_W-1:0] pend_d,
  input  logic [VEC_W-1:0] mask_d,
  output logic [LVL_W-1:0] code_q
);
  logic [VEC_W-1:0] live;
  logic [LVL_W-1:0] win_lvl;

  assign live    = pend_d & mask_d;
  assign win_lvl = irqc_select(live, NUM_SRC);

  always_ff @(posedge clk) begin
    if (rst) code_q <= '0;
    else     code_q <= irqc_invert(win_lvl);
  end
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs #(
  parameter int                 DATA_W   = 16,
  parameter int                 ADDR_W   = 6,
  parameter logic [ADDR_W-1:0]  OFF_MASK = 6'h00,
  parameter logic [ADDR_W-1:0]  OFF_PWR  = 6'h30,
  parameter logic [ADDR_W-1:0]  OFF_VER  = 6'h32,
  parameter logic [ADDR_W-1:0]  OFF_PORT = 6'h36,
  parameter logic [DATA_W-1:0]  VERSION  = 16'h0010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wen,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] mask_d,
  output logic [DATA_W-1:0] mask_q,
  output logic [DATA_W-1:0] port_q,
  output logic              pwr_q
);
  logic hit_mask, hit_port, hit_pwr;

  assign hit_mask = wen && (addr == OFF_MASK);
  assign hit_port = wen && (addr == OFF_PORT);
  assign hit_pwr  = wen && (addr == OFF_PWR) && wdata[0];
  assign mask_d   = hit_mask ? wdata : mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      port_q <= '0;
      pwr_q  <= 1'b0;
    end else begin
      mask_q <= mask_d;
      if (hit_port) port_q <= wdata;
      pwr_q  <= hit_pwr;
    end
  end

  always_comb begin
    case (addr)
      OFF_MASK: rdata = mask_q;
      OFF_PORT: rdata = port_q;
      OFF_VER:  rdata = VERSION;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_level_combiner.sv
module irq_level_combiner
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 13,
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_SRC-1:0] src,
  input  logic              reg_wen,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [DATA_W-1:0] out_port,
  output logic [IRQC_LVL_W-1:0] irl_code,
  output logic              poweroff_req
);
  logic [DATA_W-1:0] pend_d, pend_q;
  logic [DATA_W-1:0] mask_d, mask_q;

  irqc_pending #(.NUM_SRC(NUM_SRC), .VEC_W(DATA_W)) u_pend (
    .clk(clk), .rst(rst), .src(src), .pend_d(pend_d), .pend_q(pend_q)
  );

  irqc_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wen(reg_wen), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .mask_d(mask_d), .mask_q(mask_q), .port_q(out_port),
    .pwr_q(poweroff_req)
  );

  irqc_encoder #(.NUM_SRC(NUM_SRC), .VEC_W(DATA_W), .LVL_W(IRQC_LVL_W)) u_enc (
    .clk(clk), .rst(rst), .pend_d(pend_d), .mask_d(mask_d), .code_q(irl_code)
  );
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wen,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [3:0]        irl_code,
  input logic              poweroff_req,
  input logic [DATA_W-1:0] pend_q,
  input logic [DATA_W-1:0] mask_q
);
  logic pwr_write, mapped;
  assign pwr_write = reg_wen && (reg_addr == 6'h30) && reg_wdata[0];
  assign mapped    = (reg_addr == 6'h00) || (reg_addr == 6'h30) ||
                     (reg_addr == 6'h32) || (reg_addr == 6'h36);

  assert_code_live_R2: assert property (@(posedge clk) disable iff (rst)
    (irl_code != 4'd0) |-> ((pend_q & mask_q) != '0));
  assert_code_idle_R2: assert property (@(posedge clk) disable iff (rst)
    ((pend_q & mask_q) == '0) |-> (irl_code == 4'd0));
  assert_pend_unused_R1: assert property (@(posedge clk) disable iff (rst)
    pend_q[3:1] == 3'b000);
  assert_mask_read_R5: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == 6'h00) |-> (reg_rdata == mask_q));
  assert_pwr_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    pwr_write |=> poweroff_req);
  assert_pwr_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !pwr_write |=> !poweroff_req);
  assert_version_R8: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == 6'h32) |-> (reg_rdata == 16'h0010));
  assert_unmapped_R9: assert property (@(posedge clk) disable iff (rst)
    !mapped |-> (reg_rdata == '0));
  assert_reset_R10: assert property (@(posedge clk)
    $past(rst) |-> (irl_code == 4'd0 && !poweroff_req && mask_q == '0));
endmodule

bind irq_level_combiner irqc_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .reg_wen(reg_wen), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irl_code(irl_code),
  .poweroff_req(poweroff_req), .pend_q(pend_q), .mask_q(mask_q)
);

// File: tb/sim_irq_level_combiner.sv
`timescale 1ns/1ps
module sim_irq_level_combiner;
  logic        clk = 1'b0;
  logic        rst;
  logic [12:0] src;
  logic        wen;
  logic [5:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic [15:0] port;
  logic [3:0]  code;
  logic        pwr;

  always #2.5 clk = ~clk;

  irq_level_combiner u0 (
    .clk(clk), .rst(rst), .src(src), .reg_wen(wen), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .out_port(port), .irl_code(code),
    .poweroff_req(pwr)
  );

  int nvec = 0;
  int nbad = 0;

  // Reference state
  logic [15:0] m_mask = '0, m_port = '0;
  logic [12:0] m_src = '0;
  logic        m_pwr = 1'b0;
  int posn[13] = '{11, 9, 8, 12, 10, 6, 5, 4, 7, 14, 13, 0, 15};

  function automatic logic [3:0] exp_code();
    int lvl = 15;
    for (int k = 12; k >= 0; k--)
      if (m_src[k] && m_mask[posn[k]]) lvl = k;
    return 4'(15 - lvl);
  endfunction

  function automatic logic [15:0] exp_rd(input logic [5:0] a);
    if (a == 6'h00) return m_mask;
    if (a == 6'h36) return m_port;
    if (a == 6'h32) return 16'h0010;
    return 16'h0000;
  endfunction

  function automatic string rd_tag(input logic [5:0] a);
    if (a == 6'h00) return "R5";
    if (a == 6'h36) return "R6";
    if (a == 6'h30) return "R7";
    if (a == 6'h32) return "R8";
    return "R9";
  endfunction

  task automatic check(input string tag, input string what, input logic [15:0] got,
                       input logic [15:0] exp);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  // One cycle: drive at negedge, check read, update model at edge, check outputs.
  task automatic step(input logic r, input logic [12:0] s, input logic w,
                      input logic [5:0] a, input logic [15:0] d, input string tag);
    rst = r; src = s; wen = w; addr = a; wdata = d;
    #1;
    if (!r) check(rd_tag(a), "rdata", rdata, exp_rd(a));
    @(posedge clk);
    if (r) begin
      m_mask = '0; m_port = '0; m_src = '0; m_pwr = 1'b0;
    end else begin
      m_src = s;
      if (w && a == 6'h00) m_mask = d;
      if (w && a == 6'h36) m_port = d;
      m_pwr = w && (a == 6'h30) && d[0];
    end
    @(negedge clk);
    check(tag, "irl_code", {12'h0, code}, {12'h0, exp_code()});
    check("R7", "poweroff_req", {15'h0, pwr}, {15'h0, m_pwr});
    check("R6", "out_port", port, m_port);
  endtask

  task automatic idle(input logic [12:0] s, input logic [5:0] a, input string tag);
    step(1'b0, s, 1'b0, a, 16'h0, tag);
  endtask

  initial begin
    #(5.0 * 150000);
    nbad++;
    $display("FAIL watchdog: got hang expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    rst = 1'b1; src = '0; wen = 1'b0; addr = '0; wdata = '0;
    @(negedge clk);
    // R10: reset state, including reset while lines and mask were active
    step(1'b1, 13'h1FFF, 1'b1, 6'h00, 16'hFFFF, "R10");
    idle(13'h1FFF, 6'h00, "R10");
    idle(13'h1FFF, 6'h36, "R10");
    // R5: mask load and readback
    step(1'b0, 13'h0, 1'b1, 6'h00, 16'hFFFF, "R5");
    idle(13'h0, 6'h00, "R5");
    // R1: each line alone reaches its own level
    for (int k = 0; k < 13; k++) idle(13'(1 << k), 6'h00, "R1");
    // R1: only the line's own mask bit enables it
    for (int k = 0; k < 13; k++) begin
      step(1'b0, 13'h1FFF, 1'b1, 6'h00, 16'(1 << posn[k]), "R1");
      idle(13'h1FFF, 6'h00, "R1");
    end
    // R2: zero mask gives idle output; unused bits enable nothing
    step(1'b0, 13'h1FFF, 1'b1, 6'h00, 16'h000E, "R2");
    idle(13'h1FFF, 6'h00, "R2");
    step(1'b0, 13'h1FFF, 1'b1, 6'h00, 16'h0000, "R2");
    // R3: lowest level wins among several
    step(1'b0, 13'h1FFF, 1'b1, 6'h00, 16'hFFFF, "R3");
    idle(13'h1000, 6'h00, "R3");
    idle(13'h1801, 6'h00, "R3");
    idle(13'h0C20, 6'h00, "R3");
    idle(13'h0000, 6'h00, "R3");
    // R4: mask write and line change on the same edge
    step(1'b0, 13'h0000, 1'b1, 6'h00, 16'h0000, "R4");
    step(1'b0, 13'h0010, 1'b1, 6'h00, 16'h0400, "R4");
    step(1'b0, 13'h0110, 1'b1, 6'h00, 16'h0080, "R4");
    step(1'b0, 13'h0001, 1'b1, 6'h00, 16'h0800, "R4");
    // R6: output port
    step(1'b0, 13'h0, 1'b1, 6'h36, 16'hA5C3, "R6");
    idle(13'h0, 6'h36, "R6");
    // R7: power-off pulses
    step(1'b0, 13'h0, 1'b1, 6'h30, 16'h0001, "R7");
    idle(13'h0, 6'h30, "R7");
    step(1'b0, 13'h0, 1'b1, 6'h30, 16'hFFFE, "R7");
    step(1'b0, 13'h0, 1'b1, 6'h30, 16'h8001, "R7");
    step(1'b0, 13'h0, 1'b1, 6'h30, 16'h0003, "R7");
    // R8: version is fixed
    step(1'b0, 13'h0, 1'b1, 6'h32, 16'h1234, "R8");
    idle(13'h0, 6'h32, "R8");
    // R9: unmapped offsets read zero and writes go nowhere
    step(1'b0, 13'h1, 1'b1, 6'h01, 16'h0000, "R9");
    step(1'b0, 13'h1, 1'b1, 6'h37, 16'h0000, "R9");
    step(1'b0, 13'h1, 1'b1, 6'h3E, 16'h0000, "R9");
    idle(13'h1, 6'h00, "R9");
    idle(13'h1, 6'h36, "R9");
    idle(13'h1, 6'h02, "R9");
    // Mixed pseudo-random traffic, R3 and R4 jointly
    lf = 32'hACE1_2357;
    for (int n = 0; n < 400; n++) begin
      logic [5:0] a;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      case (lf[23:22])
        2'd0: a = 6'h00;
        2'd1: a = 6'h30;
        2'd2: a = 6'h36;
        default: a = lf[29:24];
      endcase
      step(1'b0, lf[12:0], lf[20] & lf[14], a, lf[31:16], "R4");
    end
    // R10: reset in mid-run
    step(1'b1, 13'h1FFF, 1'b0, 6'h00, 16'h0, "R10");
    idle(13'h0, 6'h00, "R10");
    idle(13'h0, 6'h36, "R10");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule